// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

This block is a small counter with a parallel preset. Each rising clock edge moves it by one step when both of its count enables are high. An active-low load input copies a parallel data word into the counter on the clock edge. An active-low clear input forces the state to zero. The parameter `DECADE` selects the counting mode. In binary mode the counter runs through every value of its `WIDTH` bits. In decade mode it counts 0 to 9 and then wraps.

A carry flag goes high while the counter holds its last value in the cycle, but only if the second enable is high. To chain several counters, drive the carry of one stage into the second enable of the next. The next stage then advances once per full cycle of the previous one, and an idle stage never passes a carry upward. By default the clear acts at once, with no clock edge. The parameter `SYNC_CLEAR` makes it act on the clock edge instead.

Top module: `sync_preset_counter`

## Requirements
- R1: With `SYNC_CLEAR`=0, a low `clr_n` forces `q` to zero at once, without waiting for a clock edge. The state stays zero while `clr_n` is low, whatever the other inputs do.
- R2: With `SYNC_CLEAR`=1, a low `clr_n` sets `q` to zero at the next rising edge and not before. At that edge it takes priority over load and count.
- R3: When `load_n` is low and `clr_n` is high at a rising edge, `q` takes the value of `din`. This happens whatever the enables are, so load has priority over counting.
- R4: While `load_n` is high, `din` has no effect on `q`.
- R5: When `load_n` is high and both `en_p` and `en_t` are high, `q` advances by one on each rising edge. In binary mode the all-ones value wraps to 0 (15 to 0 at the default width).
- R6: When `load_n` is high and either enable is low, `q` keeps its value across the edge.
- R7: In decade mode the counter runs 0, 1, …, 9, 0. A count step from any value of 9 or above, including the unused values 10 to 15, gives 0, so the counter cannot lock up.
- R8: `carry` is 1 exactly when `en_t` is 1 and `q` equals the last value of the cycle: all ones (15) in binary mode, 9 in decade mode. Otherwise `carry` is 0, and in particular it stays 0 whenever `en_t` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous, chosen by `SYNC_CLEAR` |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_p | input | 1 | Count enable that does not gate the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| din | input | WIDTH | Parallel preset data |
| q | output | WIDTH | Counter state |
| carry | output | 1 | Last-value flag for cascading, gated by `en_t` |

## Verification
The properties assume that `clr_n`, when it is not a reset in progress, stays steady from one rising edge to the next. A low pulse on the asynchronous clear that starts and ends between two edges would make the count and hold checks compare against a state that no longer exists. The bench changes every input, including `clr_n`, one time unit after a rising edge. Each clear it applies lasts at least one full edge, and it releases the clear only after that edge. The data and enable inputs are assumed to be known values at every sampled edge once reset has been released, and the bench always drives them to defined values.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

   // Operation selected for the next clock edge (clear is handled by the register)
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_LOAD  = 2'd1,
      OP_COUNT = 2'd2
   } ctr_op_e;

   // Final value of the counting cycle for a given width and mode
   function automatic int unsigned last_value(input int unsigned width, input bit decade);
      return decade ? 32'd9 : ((32'd1 << width) - 32'd1);
   endfunction

endpackage

// File: rtl/ctr_step.sv
module ctr_step #(
   parameter int WIDTH  = 4,
   parameter bit DECADE = 1'b0
) (
   input  ctr_pkg::ctr_op_e   op,
   input  logic [WIDTH-1:0]   cur,
   input  logic [WIDTH-1:0]   din,
   output logic [WIDTH-1:0]   nxt
);
   localparam logic [WIDTH-1:0] LAST = WIDTH'(ctr_pkg::last_value(WIDTH, DECADE));
   localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

   logic [WIDTH-1:0] inc;

   generate
      if (DECADE) begin : g_decade
         // any value at or past the last one folds back to zero
         always_comb inc = (cur >= LAST) ? '0 : cur + ONE;
      end else begin : g_binary
         // natural wrap of the adder
         always_comb inc = cur + ONE;
      end
   endgenerate

   always_comb begin
      unique case (op)
         ctr_pkg::OP_LOAD:  nxt = din;
         ctr_pkg::OP_COUNT: nxt = inc;
         default:           nxt = cur;
      endcase
   end
endmodule

// File: rtl/ctr_store.sv
module ctr_store #(
   parameter int WIDTH      = 4,
   parameter bit SYNC_CLEAR = 1'b0
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic [WIDTH-1:0] nxt,
   output logic [WIDTH-1:0] cur
);
   generate
      if (SYNC_CLEAR) begin : g_sync_clr
         always_ff @(posedge clk) begin
            if (!clr_n) cur <= '0;
            else        cur <= nxt;
         end
      end else begin : g_async_clr
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) cur <= '0;
            else        cur <= nxt;
         end
      end
   endgenerate
endmodule

// File: rtl/ctr_flag.sv
module ctr_flag #(
   parameter int WIDTH  = 4,
   parameter bit DECADE = 1'b0
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             gate,
   output logic             flag
);
   localparam logic [WIDTH-1:0] LAST = WIDTH'(ctr_pkg::last_value(WIDTH, DECADE));

   always_comb flag = gate && (cur == LAST);
endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter #(
   parameter int WIDTH      = 4,
   parameter bit DECADE     = 1'b0,
   parameter bit SYNC_CLEAR = 1'b0
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             load_n,
   input  logic             en_p,
   input  logic             en_t,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q,
   output logic             carry
);
   generate
      if (WIDTH < 1 || WIDTH > 31) begin : g_bad_width
         $error("sync_preset_counter: WIDTH must be 1..31");
      end
      if (DECADE && WIDTH < 4) begin : g_bad_decade
         $error("sync_preset_counter: decade mode needs WIDTH >= 4");
      end
   endgenerate

   ctr_pkg::ctr_op_e op;
   logic [WIDTH-1:0] nxt;

   // priority: load, then count, then hold (clear lives in the register)
   always_comb begin
      if (!load_n)            op = ctr_pkg::OP_LOAD;
      else if (en_p && en_t)  op = ctr_pkg::OP_COUNT;
      else                    op = ctr_pkg::OP_HOLD;
   end

   ctr_step #(.WIDTH(WIDTH), .DECADE(DECADE)) u_step (
      .op  (op),
      .cur (q),
      .din (din),
      .nxt (nxt)
   );

   ctr_store #(.WIDTH(WIDTH), .SYNC_CLEAR(SYNC_CLEAR)) u_store (
      .clk   (clk),
      .clr_n (clr_n),
      .nxt   (nxt),
      .cur   (q)
   );

   ctr_flag #(.WIDTH(WIDTH), .DECADE(DECADE)) u_flag (
      .cur  (q),
      .gate (en_t),
      .flag (carry)
   );
endmodule

// File: rtl/sync_preset_counter_chk.sv
module sync_preset_counter_chk #(
   parameter int WIDTH  = 4,
   parameter bit DECADE = 1'b0
) (
   input logic             clk,
   input logic             clr_n,
   input logic             load_n,
   input logic             en_p,
   input logic             en_t,
   input logic [WIDTH-1:0] din,
   input logic [WIDTH-1:0] q,
   input logic             carry
);
   localparam logic [WIDTH-1:0] LAST = WIDTH'(ctr_pkg::last_value(WIDTH, DECADE));

   function automatic logic [WIDTH-1:0] step_of(input logic [WIDTH-1:0] v);
      return (v >= LAST) ? '0 : v + WIDTH'(1);
   endfunction

   // R1 / R2: a clear seen at an edge leaves zero by the following edge
   p_clear_zero_r1: assert property (@(posedge clk) !clr_n |=> q == '0);

   // R3: load copies data whatever the enables are
   p_load_copy_r3: assert property (@(posedge clk) disable iff (!clr_n)
      !load_n |=> q == $past(din));

   // R5 / R7: enabled count steps by one, folding at the last value
   p_count_step_r5: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && en_p && en_t) |=> q == step_of($past(q)));

   // R6: a missing enable freezes the state
   p_hold_state_r6: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && !(en_p && en_t)) |=> $stable(q));

   // R8: carry never leaves an idle stage
   p_carry_gated_r8: assert property (@(posedge clk) disable iff (!clr_n)
      !en_t |-> !carry);

   // R8: carry only at the last value
   p_carry_last_r8: assert property (@(posedge clk) disable iff (!clr_n)
      carry |-> (q == LAST));
endmodule

bind sync_preset_counter sync_preset_counter_chk #(.WIDTH(WIDTH), .DECADE(DECADE)) u_chk (
   .clk    (clk),
   .clr_n  (clr_n),
   .load_n (load_n),
   .en_p   (en_p),
   .en_t   (en_t),
   .din    (din),
   .q      (q),
   .carry  (carry)
);

// File: tb/sync_preset_counter_test.sv
`timescale 1ns/100ps
module sync_preset_counter_test;
   logic clk = 1'b0;
   logic clr_n = 1'b0, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
   logic [3:0] din = 4'd0;
   logic [3:0] q_b, q_d, q_s;
   logic c_b, c_d, c_s;
   int checks = 0, failures = 0, cyc = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   // binary, asynchronous clear
   sync_preset_counter #(.WIDTH(4), .DECADE(1'b0), .SYNC_CLEAR(1'b0)) uut (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
      .din(din), .q(q_b), .carry(c_b));
   // decade, asynchronous clear
   sync_preset_counter #(.WIDTH(4), .DECADE(1'b1), .SYNC_CLEAR(1'b0)) uut_dec (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
      .din(din), .q(q_d), .carry(c_d));
   // binary, synchronous clear
   sync_preset_counter #(.WIDTH(4), .DECADE(1'b0), .SYNC_CLEAR(1'b1)) uut_sc (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
      .din(din), .q(q_s), .carry(c_s));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic int nxt_bin(input int v);
      return (v + 1) % 16;
   endfunction

   function automatic int nxt_dec(input int v);
      return (v >= 9) ? 0 : v + 1;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000 && !done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // reset state, all variants held in clear
      tick(); tick(); tick();
      chk("R1 reset bin", q_b, 0);
      chk("R1 reset dec", q_d, 0);
      chk("R2 reset sync", q_s, 0);
      chk("R8 reset carry", {c_b, c_d, c_s}, 0);
      clr_n = 1'b1;

      // load, hold with data changing, then one count, for every value
      for (int v = 0; v < 16; v++) begin
         load_n = 1'b0; en_p = 1'b0; en_t = 1'b0; din = 4'(v);
         tick();
         chk("R3 load bin", q_b, v);
         chk("R3 load dec", q_d, v);
         chk("R3 load sync", q_s, v);
         chk("R8 carry off en_t low", {c_b, c_d}, 0);
         load_n = 1'b1; en_t = 1'b1; en_p = 1'b0; din = ~4'(v);
         tick();
         chk("R4 R6 hold bin", q_b, v);
         chk("R4 R6 hold dec", q_d, v);
         chk("R8 carry bin", c_b, (v == 15) ? 1 : 0);
         chk("R8 carry dec", c_d, (v == 9) ? 1 : 0);
         en_p = 1'b1;
         tick();
         chk("R5 step bin", q_b, nxt_bin(v));
         chk("R7 step dec", q_d, nxt_dec(v));
         chk("R5 step sync", q_s, nxt_bin(v));
         en_p = 1'b0; en_t = 1'b0;
      end

      // load beats count
      load_n = 1'b0; en_p = 1'b1; en_t = 1'b1; din = 4'd3;
      tick();
      chk("R3 load over count bin", q_b, 3);
      chk("R3 load over count dec", q_d, 3);

      // long count from zero
      load_n = 1'b1; clr_n = 1'b0;
      tick();
      clr_n = 1'b1;
      for (int k = 1; k <= 40; k++) begin
         tick();
         chk("R5 run bin", q_b, k % 16);
         chk("R7 run dec", q_d, k % 10);
         chk("R8 run carry bin", c_b, (k % 16 == 15) ? 1 : 0);
         chk("R8 run carry dec", c_d, (k % 10 == 9) ? 1 : 0);
      end

      // enable gating: 40 % 10 = 0, 40 % 16 = 8 now; move to 9 / 15 region
      load_n = 1'b0; din = 4'd9;
      tick();
      load_n = 1'b1; en_p = 1'b1; en_t = 1'b0;
      tick();
      chk("R6 hold en_t low dec", q_d, 9);
      chk("R8 carry blocked dec", c_d, 0);
      en_p = 1'b0; en_t = 1'b1;
      tick();
      chk("R6 hold en_p low dec", q_d, 9);
      chk("R8 carry at nine dec", c_d, 1);
      en_t = 1'b0;

      // clear variants: async acts between edges, sync waits for edge
      load_n = 1'b0; din = 4'd5;
      tick();
      load_n = 1'b1;
      clr_n = 1'b0; load_n = 1'b0; din = 4'd7;
      #0.5;
      chk("R1 async clear bin", q_b, 0);
      chk("R1 async clear dec", q_d, 0);
      chk("R2 sync clear waits", q_s, 5);
      tick();
      chk("R2 sync clear over load", q_s, 0);
      chk("R1 clear over load bin", q_b, 0);
      clr_n = 1'b1; load_n = 1'b1;
      tick();

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule